// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block takes a chip out of its low-power standby state in an orderly way. While the chip sleeps, the block watches several wake sources: a non-maskable interrupt, a 4-bit encoded interrupt level compared against the current mask level, a group of IRQ lines (each one level- or edge-sensitive), port interrupts and peripheral interrupts. It also watches a synchronous manual reset request. When a qualifying request arrives, the block records which class of source caused it. It then loads an 8-bit settling counter with a start value that software programmed earlier, and keeps the system clock gated off until that counter, advanced by a prescaled tick, wraps past its all-ones value.

Once the clock is back on, the same counter keeps running as a guard timer. Software must acknowledge the wake-up by clearing the standby flag before the counter reaches its midpoint. A missed acknowledge is taken as a sign of an unstable supply, and the block falls into a locked standby state that only the power-on reset can end.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After power-on reset the block is in the run state: clk_gate_en=1, stat_o=2'b00, settle_cnt=0, src_code=0.
- R2: A one-cycle sleep_req in the run state enters standby on the next clock edge: clk_gate_en=0, stat_o=2'b10.
- R3: The encoded level irl_lvl wakes the block only when it is strictly greater than irl_mask. Equal or lower levels are ignored.
- R4: An IRQ line whose irq_edge_sel bit is 0 wakes on a high level. With the bit at 1 it wakes only on a rising edge seen while in standby, so a line already held high does not wake. Peripheral bit 0 (the interval timer) never wakes. The other peripheral bits and every port line wake on a high level.
- R5: The source code is captured on the edge that accepts the wake. The codes are NMI=1, level=2, IRQ=3, port=4, peripheral=5, in that priority order. The code is 0 after any reset.
- R6: On wake the counter loads the programmed start value and advances by one on each cycle with tick_en=1. The clock stays gated and stat_o stays 2'b10 until the counter wraps from 0xFF to 0x00. On that edge clk_gate_en becomes 1 and stat_o 2'b00.
- R7: A start-value write (cfg_wr) is accepted only in the run state. Writes in any other state leave the loaded value unchanged.
- R8: After wake, stby_clr returns the block to the run state and halts the counter at its current value, even when a tick occurs in the same cycle.
- R9: If the counter reaches 0x80 after wake without stby_clr, the block enters locked standby: clk_gate_en=0, stat_o=2'b10, counter frozen. All wake requests, mrst_req and stby_clr are then ignored, and only rst_n leaves this state.
- R10: mrst_req in standby, settling or guard returns the block to the run state with the counter and the source code cleared.
- R11: Wake requests arriving outside the standby state do not change the source code or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| tick_en | input | 1 | Prescaled counting enable |
| mrst_req | input | 1 | Synchronous manual reset request |
| sleep_req | input | 1 | Enter standby (run state only) |
| stby_clr | input | 1 | Software clears the standby flag |
| cfg_wr | input | 1 | Write strobe for the counter start value |
| cfg_data | input | 8 | Counter start value |
| nmi | input | 1 | Non-maskable interrupt |
| irl_lvl | input | 4 | Encoded interrupt level |
| irl_mask | input | 4 | Current interrupt mask level |
| irq | input | 4 | IRQ lines |
| irq_edge_sel | input | 4 | Per-line edge (1) or level (0) select |
| pint | input | 2 | Port interrupt lines |
| periph | input | 4 | Peripheral interrupts, bit 0 is the interval timer |
| clk_gate_en | output | 1 | System clock enable |
| stat_o | output | 2 | Status pins, 00 running, 10 standby |
| src_code | output | 3 | Captured wake source code |
| settle_cnt | output | 8 | Settling/guard counter value |

## Verification
Every output is registered. A wake request, sleep request, reset request or tick is therefore visible on the ports one clock edge after the cycle in which it is driven. The bench drives inputs just after a falling edge and samples at the next falling edge, so each check sees exactly one rising edge. Settle and guard durations are counted in ticks. With a start value S and a tick every cycle, the clock comes back 256-S edges after the wake edge, and locking happens on the 128th edge after that. The bench checks both the last cycle before each of these events and the cycle of the event.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_STBY   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_GUARD  = 3'd3,
    ST_LOCK   = 3'd4
  } wake_state_e;

  localparam logic [2:0] SRC_NONE   = 3'd0;
  localparam logic [2:0] SRC_NMI    = 3'd1;
  localparam logic [2:0] SRC_LVL    = 3'd2;
  localparam logic [2:0] SRC_IRQ    = 3'd3;
  localparam logic [2:0] SRC_PORT   = 3'd4;
  localparam logic [2:0] SRC_PERIPH = 3'd5;

  localparam logic [1:0] STAT_RUN  = 2'b00;
  localparam logic [1:0] STAT_STBY = 2'b10;
endpackage

// File: rtl/stby_wake_detect.sv
module stby_wake_detect #(
  parameter int LVL_W = 4,
  parameter int NIRQ  = 4,
  parameter int NPINT = 2,
  parameter int NPER  = 4,
  parameter logic [NPER-1:0] PER_WAKE_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi,
  input  logic [LVL_W-1:0] irl_lvl,
  input  logic [LVL_W-1:0] irl_mask,
  input  logic [NIRQ-1:0]  irq,
  input  logic [NIRQ-1:0]  irq_edge_sel,
  input  logic [NPINT-1:0] pint,
  input  logic [NPER-1:0]  periph,
  output logic             wake_any,
  output logic [2:0]       wake_code
);
  import stby_wake_pkg::*;

  logic [NIRQ-1:0] irq_prev_q;
  logic [NIRQ-1:0] irq_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_prev_q <= '0;
    else        irq_prev_q <= irq;
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    assign irq_hit[i] = irq_edge_sel[i] ? (irq[i] & ~irq_prev_q[i]) : irq[i];
  end

  logic lvl_hit, irq_any, pint_any, per_any;
  assign lvl_hit  = irl_lvl > irl_mask;
  assign irq_any  = |irq_hit;
  assign pint_any = |pint;
  assign per_any  = |(periph & PER_WAKE_MASK);

  always_comb begin
    wake_code = SRC_NONE;
    if (nmi)           wake_code = SRC_NMI;
    else if (lvl_hit)  wake_code = SRC_LVL;
    else if (irq_any)  wake_code = SRC_IRQ;
    else if (pint_any) wake_code = SRC_PORT;
    else if (per_any)  wake_code = SRC_PERIPH;
  end

  assign wake_any = (wake_code != SRC_NONE);
endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [W-1:0] cfg_data,
  input  logic         cfg_ok,
  input  logic         clear,
  input  logic         load,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] start_val,
  output logic         at_max,
  output logic         at_pre_mid
);
  localparam logic [W-1:0] MAX_V     = '1;
  localparam logic [W-1:0] PRE_MID_V = MAX_V >> 1;

  logic [W-1:0] cnt_q, cnt_d, start_q, start_d;

  always_comb begin
    start_d = start_q;
    if (cfg_wr && cfg_ok) start_d = cfg_data;
    cnt_d = cnt_q;
    if (clear)      cnt_d = '0;
    else if (load)  cnt_d = start_q;
    else if (inc)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign cnt        = cnt_q;
  assign start_val  = start_q;
  assign at_max     = (cnt_q == MAX_V);
  assign at_pre_mid = (cnt_q == PRE_MID_V);
endmodule

// File: rtl/stby_seq_fsm.sv
module stby_seq_fsm (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mrst_req,
  input  logic                       sleep_req,
  input  logic                       stby_clr,
  input  logic                       tick_en,
  input  logic                       wake_any,
  input  logic                       at_max,
  input  logic                       at_pre_mid,
  output stby_wake_pkg::wake_state_e state_q,
  output logic                       cnt_clear,
  output logic                       cnt_load,
  output logic                       cnt_inc
);
  import stby_wake_pkg::*;

  wake_state_e state_d;

  always_comb begin
    state_d   = state_q;
    cnt_clear = 1'b0;
    cnt_load  = 1'b0;
    cnt_inc   = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (mrst_req)       cnt_clear = 1'b1;
        else if (sleep_req) state_d = ST_STBY;
      end
      ST_STBY: begin
        if (mrst_req) begin
          cnt_clear = 1'b1;
          state_d   = ST_RUN;
        end else if (wake_any) begin
          cnt_load = 1'b1;
          state_d  = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (mrst_req) begin
          cnt_clear = 1'b1;
          state_d   = ST_RUN;
        end else if (tick_en) begin
          cnt_inc = 1'b1;
          if (at_max) state_d = ST_GUARD;
        end
      end
      ST_GUARD: begin
        if (mrst_req) begin
          cnt_clear = 1'b1;
          state_d   = ST_RUN;
        end else if (stby_clr) begin
          state_d = ST_RUN;
        end else if (tick_en) begin
          cnt_inc = 1'b1;
          if (at_pre_mid) state_d = ST_LOCK;
        end
      end
      ST_LOCK: state_d = ST_LOCK;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl #(
  parameter int CNT_W = 8,
  parameter int LVL_W = 4,
  parameter int NIRQ  = 4,
  parameter int NPINT = 2,
  parameter int NPER  = 4,
  parameter logic [NPER-1:0] PER_WAKE_MASK = 4'b1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             mrst_req,
  input  logic             sleep_req,
  input  logic             stby_clr,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_data,
  input  logic             nmi,
  input  logic [LVL_W-1:0] irl_lvl,
  input  logic [LVL_W-1:0] irl_mask,
  input  logic [NIRQ-1:0]  irq,
  input  logic [NIRQ-1:0]  irq_edge_sel,
  input  logic [NPINT-1:0] pint,
  input  logic [NPER-1:0]  periph,
  output logic             clk_gate_en,
  output logic [1:0]       stat_o,
  output logic [2:0]       src_code,
  output logic [CNT_W-1:0] settle_cnt
);
  import stby_wake_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  wake_state_e      state_q;
  logic             wake_any, cnt_clear, cnt_load, cnt_inc, at_max, at_pre_mid;
  logic [2:0]       wake_code, src_q, src_d;
  logic [CNT_W-1:0] start_val;

  stby_wake_detect #(
    .LVL_W(LVL_W), .NIRQ(NIRQ), .NPINT(NPINT), .NPER(NPER),
    .PER_WAKE_MASK(PER_WAKE_MASK)
  ) u_detect (
    .clk(clk), .rst_n(rst_sync_n), .nmi(nmi), .irl_lvl(irl_lvl),
    .irl_mask(irl_mask), .irq(irq), .irq_edge_sel(irq_edge_sel),
    .pint(pint), .periph(periph), .wake_any(wake_any), .wake_code(wake_code)
  );

  stby_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .mrst_req(mrst_req), .sleep_req(sleep_req),
    .stby_clr(stby_clr), .tick_en(tick_en), .wake_any(wake_any),
    .at_max(at_max), .at_pre_mid(at_pre_mid), .state_q(state_q),
    .cnt_clear(cnt_clear), .cnt_load(cnt_load), .cnt_inc(cnt_inc)
  );

  stby_settle_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .cfg_ok(state_q == ST_RUN), .clear(cnt_clear), .load(cnt_load),
    .inc(cnt_inc), .cnt(settle_cnt), .start_val(start_val),
    .at_max(at_max), .at_pre_mid(at_pre_mid)
  );

  always_comb begin
    src_d = src_q;
    if (cnt_clear)     src_d = SRC_NONE;
    else if (cnt_load) src_d = wake_code;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) src_q <= SRC_NONE;
    else             src_q <= src_d;
  end

  assign src_code    = src_q;
  assign clk_gate_en = (state_q == ST_RUN) || (state_q == ST_GUARD);
  assign stat_o      = clk_gate_en ? STAT_RUN : STAT_STBY;
endmodule

// File: rtl/stby_wake_ctrl_chk.sv
module stby_wake_ctrl_chk (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic                       mrst_req,
  input logic                       stby_clr,
  input logic [3:0]                 irl_lvl,
  input logic [3:0]                 irl_mask,
  input logic                       clk_gate_en,
  input logic [2:0]                 src_code,
  input logic [7:0]                 settle_cnt,
  input logic [7:0]                 start_val,
  input stby_wake_pkg::wake_state_e state_q
);
  import stby_wake_pkg::*;

  assert_clk_back_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(clk_gate_en) |-> settle_cnt == 8'h00);

  assert_lock_at_mid_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_LOCK && $past(state_q) == ST_GUARD) |-> settle_cnt == 8'h80);

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    state_q == ST_LOCK |=> (state_q == ST_LOCK && $stable(settle_cnt)));

  assert_cfg_only_run_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    state_q != ST_RUN |=> $stable(start_val));

  assert_src_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(src_code) |-> ($past(state_q) == ST_STBY || src_code == SRC_NONE));

  assert_clr_halts_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_GUARD && stby_clr && !mrst_req) |=>
      (state_q == ST_RUN && $stable(settle_cnt)));

  assert_lvl_strict_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_SETTLE && $past(state_q) == ST_STBY && src_code == SRC_LVL) |->
      $past(irl_lvl > irl_mask));
endmodule

bind stby_wake_ctrl stby_wake_ctrl_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .mrst_req(mrst_req), .stby_clr(stby_clr),
  .irl_lvl(irl_lvl), .irl_mask(irl_mask), .clk_gate_en(clk_gate_en),
  .src_code(src_code), .settle_cnt(settle_cnt), .start_val(start_val),
  .state_q(state_q)
);

// File: tb/stby_wake_ctrl_bench.sv
module stby_wake_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick_en, mrst_req, sleep_req, stby_clr, cfg_wr, nmi;
  logic [7:0] cfg_data;
  logic [3:0] irl_lvl, irl_mask, irq, irq_edge_sel, periph;
  logic [1:0] pint;
  logic clk_gate_en;
  logic [1:0] stat_o;
  logic [2:0] src_code;
  logic [7:0] settle_cnt;

  stby_wake_ctrl u_stby_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mrst_req(mrst_req),
    .sleep_req(sleep_req), .stby_clr(stby_clr), .cfg_wr(cfg_wr),
    .cfg_data(cfg_data), .nmi(nmi), .irl_lvl(irl_lvl), .irl_mask(irl_mask),
    .irq(irq), .irq_edge_sel(irq_edge_sel), .pint(pint), .periph(periph),
    .clk_gate_en(clk_gate_en), .stat_o(stat_o), .src_code(src_code),
    .settle_cnt(settle_cnt)
  );

  int checks = 0, errors = 0, cyc_n = 0;
  bit done = 1'b0;

  // {nmi, lvl[4], mask[4], irq[4], edge_sel[4], pint[2], periph[4], code[3]}
  localparam logic [25:0] VECS [11] = '{
    {1'b1, 4'h0, 4'h0, 4'h1, 4'h0, 2'b01, 4'h4, 3'd1},
    {1'b0, 4'h5, 4'h3, 4'h0, 4'h0, 2'b00, 4'h0, 3'd2},
    {1'b0, 4'h3, 4'h3, 4'h0, 4'h0, 2'b00, 4'h0, 3'd0},
    {1'b0, 4'h2, 4'h3, 4'h1, 4'h0, 2'b00, 4'h0, 3'd3},
    {1'b0, 4'h0, 4'h0, 4'h2, 4'h2, 2'b00, 4'h0, 3'd3},
    {1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 2'b01, 4'h0, 3'd4},
    {1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 2'b00, 4'h1, 3'd0},
    {1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 2'b00, 4'h4, 3'd5},
    {1'b0, 4'hF, 4'hE, 4'h1, 4'h0, 2'b01, 4'h2, 3'd2},
    {1'b0, 4'h0, 4'h0, 4'h1, 4'h0, 2'b10, 4'h0, 3'd3},
    {1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 2'b10, 4'h8, 3'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_out(input string req, input int en, input int st,
                         input int src, input int cnt);
    chk({req, " clk_gate_en"}, clk_gate_en, en);
    chk({req, " stat_o"}, stat_o, st);
    chk({req, " src_code"}, src_code, src);
    chk({req, " settle_cnt"}, settle_cnt, cnt);
  endtask

  task automatic clear_wake;
    nmi = 0; irl_lvl = 0; irl_mask = 0; irq = 0; irq_edge_sel = 0;
    pint = 0; periph = 0;
  endtask

  task automatic pulse_mrst;
    mrst_req = 1; cyc(); mrst_req = 0;
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick_en = 0; mrst_req = 0; sleep_req = 0; stby_clr = 0;
    cfg_wr = 0; cfg_data = 0;
    clear_wake();
    cyc(3);
    rst_n = 1;
    cyc(4);
    chk_out("R1 reset", 1, 2'b00, 0, 0);

    // table walk
    foreach (VECS[i]) begin
      logic [25:0] v;
      v = VECS[i];
      cfg_wr = 1; cfg_data = 8'hF0; cyc(); cfg_wr = 0;
      sleep_req = 1; cyc(); sleep_req = 0;
      chk("R2 enter standby stat_o", stat_o, 2'b10);
      chk("R2 enter standby clk_gate_en", clk_gate_en, 0);
      nmi = v[25]; irl_lvl = v[24:21]; irl_mask = v[20:17]; irq = v[16:13];
      irq_edge_sel = v[12:9]; pint = v[8:7]; periph = v[6:3];
      cyc();
      clear_wake();
      chk("R5 R3 R4 vector src_code", src_code, v[2:0]);
      chk("R6 vector settle_cnt", settle_cnt, (v[2:0] != 0) ? 8'hF0 : 8'h00);
      chk("R6 vector clk gated", clk_gate_en, 0);
      pulse_mrst();
      cyc();
      chk_out("R10 manual reset", 1, 2'b00, 0, 0);
    end

    // settle timing, R6
    cfg_wr = 1; cfg_data = 8'hF0; cyc(); cfg_wr = 0;
    sleep_req = 1; cyc(); sleep_req = 0;
    nmi = 1; cyc(); nmi = 0;
    chk_out("R6 loaded", 0, 2'b10, 1, 8'hF0);
    tick_en = 1; cyc(15);
    chk_out("R6 before wrap", 0, 2'b10, 1, 8'hFF);
    cyc();
    chk_out("R6 wrap restores clock", 1, 2'b00, 1, 8'h00);
    tick_en = 0; cyc(3);
    chk("R6 no tick no count", settle_cnt, 8'h00);
    tick_en = 1; cyc(10);
    chk("R8 guard keeps counting", settle_cnt, 8'h0A);
    nmi = 1; cyc(); nmi = 0;
    chk_out("R11 wake in guard ignored", 1, 2'b00, 1, 8'h0B);
    stby_clr = 1; cyc(); stby_clr = 0;
    chk_out("R8 clear halts", 1, 2'b00, 1, 8'h0B);
    cyc(5);
    chk_out("R8 halted in run", 1, 2'b00, 1, 8'h0B);
    pint = 2'b01; cyc(); pint = 0;
    chk_out("R11 wake in run ignored", 1, 2'b00, 1, 8'h0B);

    // R7: write in standby ignored
    tick_en = 0;
    sleep_req = 1; cyc(); sleep_req = 0;
    cfg_wr = 1; cfg_data = 8'h10; cyc(); cfg_wr = 0;
    nmi = 1; cyc(); nmi = 0;
    chk("R7 write outside run ignored", settle_cnt, 8'hF0);

    // R9: lock
    tick_en = 1; cyc(16);
    chk_out("R9 guard entered", 1, 2'b00, 1, 8'h00);
    cyc(127);
    chk_out("R9 last guard cycle", 1, 2'b00, 1, 8'h7F);
    cyc();
    chk_out("R9 locked", 0, 2'b10, 1, 8'h80);
    nmi = 1; pint = 2'b11; mrst_req = 1; stby_clr = 1; cyc();
    clear_wake(); mrst_req = 0; stby_clr = 0;
    cyc(3);
    chk_out("R9 lock ignores requests", 0, 2'b10, 1, 8'h80);
    rst_n = 0; cyc(); rst_n = 1; cyc(3);
    chk_out("R9 R1 power-on reset exits lock", 1, 2'b00, 0, 0);

    // R10 from settling
    tick_en = 1;
    sleep_req = 1; cyc(); sleep_req = 0;
    periph = 4'h2; cyc(); periph = 0;
    cyc(3);
    chk_out("R10 settling counts", 0, 2'b10, 5, 3);
    pulse_mrst(); cyc();
    chk_out("R10 reset from settling", 1, 2'b00, 0, 0);

    // R4 edge line held high
    tick_en = 0;
    irq_edge_sel = 4'h1; irq = 4'h1; cyc();
    sleep_req = 1; cyc(); sleep_req = 0;
    cyc(3);
    chk_out("R4 held edge line no wake", 0, 2'b10, 0, 0);
    irq_edge_sel = 4'h0; cyc();
    chk("R4 level line wakes", src_code, 3);
    clear_wake(); pulse_mrst(); cyc();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule